// File: doc/BRIEF.md
# Battery-Backup Power Mode Sequencer

This controller tracks the operating mode of a metering SoC that can run either from main power or from a backup battery. It supports four modes: normal operation on main power, brownout on battery, display-only and sleep. A main-power-good indication passes through a synchronizer and a debounce filter. Together with software requests for display-only or sleep and an external wake event, this filtered indication decides which mode is current.

From the current mode the block drives a set of strobes and enables:
- the core digital supply enable
- the PLL enable and speed select
- a processor halt
- a one-cycle processor restart with its reset vector
- a one-cycle clear of the volatile configuration registers
- per-segment blink enables that only take effect while the display runs alone

The block does not model the analog supply switch, the PLL, the display drivers or the register file. It only produces the controls for them.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_o is 0 (normal), core_sup_en_o and pll_en_o are 1, and cpu_halt_o, cpu_rst_o, vol_reg_clr_o and blink_en_o are 0.
- R2: main_pwr_ok_i is resynchronized by two flops and then filtered. A level change reaches the mode logic only after it has been stable for DEB_LEN cycles, so the mode changes DEB_LEN+3 clock edges after the input changes. A shorter glitch has no effect on the mode.
- R3: In normal mode (0), loss of filtered main power moves the block to brownout (code 1). In brownout the PLL stays enabled, and pll_fast_o keeps following fast_sel_i exactly as it does in normal mode.
- R4: In brownout, return of filtered main power moves the block to normal mode with no software action and without a processor restart.
- R5: In brownout without main power, disp_req_i moves the block to display-only (code 2) and sleep_req_i moves it to sleep (code 3). If both are asserted, the display request wins. In normal mode, sleep_req_i has no effect.
- R6: A display request while filtered main power is present is accepted. Display-only mode then lasts one cycle, and the next cycle the block returns to normal mode with a restart.
- R7: In display-only and sleep mode, core_sup_en_o is 0 and cpu_halt_o is 1. In normal and brownout mode, core_sup_en_o is 1 and cpu_halt_o is 0.
- R8: In display-only mode, pll_en_o is 1 only while boost_sel_i equals 2'b10. In sleep mode, pll_en_o is 0. pll_fast_o is pll_en_o AND fast_sel_i in every mode.
- R9: blink_en_o equals blink_sel_i in display-only mode and is all zeros in every other mode.
- R10: Display-only and sleep are left for normal mode when filtered main power is present. Without main power, wake_i moves the block to brownout. On such an exit, cpu_rst_o and vol_reg_clr_o pulse high for exactly the cycle in which the new mode first appears on mode_o, with rst_vec_o equal to RST_VEC (0 by default). No other transition pulses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr_ok_i | input | 1 | Raw main-power-good indication (asynchronous) |
| disp_req_i | input | 1 | Software request to enter display-only mode |
| sleep_req_i | input | 1 | Software request to enter sleep mode |
| wake_i | input | 1 | Wake event while in display-only or sleep mode |
| boost_sel_i | input | 2 | Display boost field; 2'b10 keeps the PLL on in display-only mode |
| fast_sel_i | input | 1 | PLL speed select; 0 selects the slow clock of about 6.29 MHz |
| blink_sel_i | input | BLINK_N | Segments allowed to blink in display-only mode |
| mode_o | output | 2 | Current mode: 0 normal, 1 brownout, 2 display-only, 3 sleep |
| core_sup_en_o | output | 1 | Core digital supply enable |
| pll_en_o | output | 1 | PLL enable |
| pll_fast_o | output | 1 | PLL fast-speed select |
| cpu_halt_o | output | 1 | Processor halt |
| cpu_rst_o | output | 1 | One-cycle processor restart |
| rst_vec_o | output | ADDR_W | Program counter value applied on restart |
| vol_reg_clr_o | output | 1 | One-cycle clear of volatile configuration registers |
| blink_en_o | output | BLINK_N | Autonomous blink enable per segment |

## Verification
The bench targets these corner cases and the failure each one would expose:
- **Debounce boundary.** A glitch one cycle shorter than the debounce length must leave the mode alone, while a longer stable drop must move it exactly DEB_LEN+3 edges later. An off-by-one filter would either switch on the glitch or switch a cycle early or late.
- **Display request on main power.** This must give a single cycle of display-only mode followed by a restart into normal mode. A design that ignores the request, or stays in display-only mode, fails that check.
- **Exits from display-only and sleep.** Each exit must produce exactly one restart and register-clear pulse. Brownout recovery must produce none.
- **Boost field in display-only mode.** The PLL enable must follow the boost field only while the display runs alone.
- **Request priority.** Random mixes of simultaneous requests test that the display request beats the sleep request, and that a sleep request in normal mode is ignored.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

   typedef enum logic [1:0] {
      MODE_NORM  = 2'd0,
      MODE_BROWN = 2'd1,
      MODE_DISP  = 2'd2,
      MODE_SLEEP = 2'd3
   } pm_mode_e;

   localparam logic [1:0] BOOST_PUMP = 2'b10;

endpackage

// File: rtl/pmseq_pgood_filt.sv
module pmseq_pgood_filt #(
   parameter int DEB_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic good_o
);
   localparam int CNT_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

   logic sync_a_q, sync_b_q, filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_a_q <= 1'b1;
         sync_b_q <= 1'b1;
      end else begin
         sync_a_q <= raw_i;
         sync_b_q <= sync_a_q;
      end
   end

   generate
      if (DEB_LEN == 1) begin : g_nocnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_q <= 1'b1;
            else        filt_q <= sync_b_q;
         end
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_q <= 1'b1;
               cnt_q  <= '0;
            end else if (sync_b_q == filt_q) begin
               cnt_q  <= '0;
            end else if (cnt_q == CNT_W'(DEB_LEN - 1)) begin
               filt_q <= sync_b_q;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign good_o = filt_q;

endmodule

// File: rtl/pmseq_mode_fsm.sv
module pmseq_mode_fsm
   import pmseq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pgood_i,
   input  logic     disp_req_i,
   input  logic     sleep_req_i,
   input  logic     wake_i,
   output pm_mode_e mode_o,
   output logic     restart_o
);
   pm_mode_e mode_q, mode_d;
   logic     restart_q;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_NORM: begin
            if (!pgood_i)        mode_d = MODE_BROWN;
            else if (disp_req_i) mode_d = MODE_DISP;
         end
         MODE_BROWN: begin
            if (pgood_i)          mode_d = MODE_NORM;
            else if (disp_req_i)  mode_d = MODE_DISP;
            else if (sleep_req_i) mode_d = MODE_SLEEP;
         end
         MODE_DISP, MODE_SLEEP: begin
            if (pgood_i)     mode_d = MODE_NORM;
            else if (wake_i) mode_d = MODE_BROWN;
         end
         default: mode_d = MODE_NORM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_NORM;
         restart_q <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         restart_q <= ((mode_q == MODE_DISP) || (mode_q == MODE_SLEEP)) &&
                      (mode_d != mode_q);
      end
   end

   assign mode_o    = mode_q;
   assign restart_o = restart_q;

endmodule

// File: rtl/pmseq_out_map.sv
module pmseq_out_map
   import pmseq_pkg::*;
#(
   parameter int BLINK_N = 2
) (
   input  pm_mode_e           mode_i,
   input  logic [1:0]         boost_sel_i,
   input  logic               fast_sel_i,
   input  logic [BLINK_N-1:0] blink_sel_i,
   output logic               core_sup_en_o,
   output logic               pll_en_o,
   output logic               pll_fast_o,
   output logic               cpu_halt_o,
   output logic [BLINK_N-1:0] blink_en_o
);
   logic disp_mode;
   logic low_mode;

   assign disp_mode     = (mode_i == MODE_DISP);
   assign low_mode      = disp_mode || (mode_i == MODE_SLEEP);
   assign core_sup_en_o = !low_mode;
   assign cpu_halt_o    = low_mode;

   always_comb begin
      unique case (mode_i)
         MODE_NORM, MODE_BROWN: pll_en_o = 1'b1;
         MODE_DISP:             pll_en_o = (boost_sel_i == BOOST_PUMP);
         default:               pll_en_o = 1'b0;
      endcase
   end

   assign pll_fast_o = pll_en_o && fast_sel_i;

   for (genvar g = 0; g < BLINK_N; g++) begin : g_blink
      assign blink_en_o[g] = disp_mode && blink_sel_i[g];
   end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pmseq_pkg::*;
#(
   parameter int                DEB_LEN = 16,
   parameter int                BLINK_N = 2,
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] RST_VEC = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               main_pwr_ok_i,
   input  logic               disp_req_i,
   input  logic               sleep_req_i,
   input  logic               wake_i,
   input  logic [1:0]         boost_sel_i,
   input  logic               fast_sel_i,
   input  logic [BLINK_N-1:0] blink_sel_i,
   output logic [1:0]         mode_o,
   output logic               core_sup_en_o,
   output logic               pll_en_o,
   output logic               pll_fast_o,
   output logic               cpu_halt_o,
   output logic               cpu_rst_o,
   output logic [ADDR_W-1:0]  rst_vec_o,
   output logic               vol_reg_clr_o,
   output logic [BLINK_N-1:0] blink_en_o
);
   initial begin
      if (DEB_LEN < 1) $error("DEB_LEN must be at least 1");
      if (BLINK_N < 1 || BLINK_N > 2) $error("BLINK_N must be 1 or 2");
      if (ADDR_W < 1) $error("ADDR_W must be positive");
   end

   logic     pgood;
   logic     restart;
   pm_mode_e mode;

   pmseq_pgood_filt #(.DEB_LEN(DEB_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (main_pwr_ok_i),
      .good_o (pgood)
   );

   pmseq_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pgood_i     (pgood),
      .disp_req_i  (disp_req_i),
      .sleep_req_i (sleep_req_i),
      .wake_i      (wake_i),
      .mode_o      (mode),
      .restart_o   (restart)
   );

   pmseq_out_map #(.BLINK_N(BLINK_N)) u_map (
      .mode_i        (mode),
      .boost_sel_i   (boost_sel_i),
      .fast_sel_i    (fast_sel_i),
      .blink_sel_i   (blink_sel_i),
      .core_sup_en_o (core_sup_en_o),
      .pll_en_o      (pll_en_o),
      .pll_fast_o    (pll_fast_o),
      .cpu_halt_o    (cpu_halt_o),
      .blink_en_o    (blink_en_o)
   );

   assign mode_o        = mode;
   assign cpu_rst_o     = restart;
   assign vol_reg_clr_o = restart;
   assign rst_vec_o     = RST_VEC;

endmodule

// File: rtl/pmseq_chk.sv
module pmseq_chk #(
   parameter int BLINK_N = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_o,
   input logic               core_sup_en_o,
   input logic               pll_en_o,
   input logic [1:0]         boost_sel_i,
   input logic               cpu_rst_o,
   input logic               cpu_halt_o,
   input logic [BLINK_N-1:0] blink_en_o
);
   AST_LOW_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[1]) |-> (!core_sup_en_o && cpu_halt_o)); // R7

   AST_DISP_PLL_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd2 && boost_sel_i != 2'b10) |-> !pll_en_o); // R8

   AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |=> !cpu_rst_o); // R10

   AST_RESTART_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |-> ($past(mode_o) >= 2'd2 && mode_o <= 2'd1)); // R10

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3 && $past(mode_o) != 2'd3) |-> ($past(mode_o) == 2'd1)); // R5

   AST_NO_BLINK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd2) |-> (blink_en_o == '0)); // R9

endmodule

bind pwr_mode_seq pmseq_chk #(.BLINK_N(BLINK_N)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_o        (mode_o),
   .core_sup_en_o (core_sup_en_o),
   .pll_en_o      (pll_en_o),
   .boost_sel_i   (boost_sel_i),
   .cpu_rst_o     (cpu_rst_o),
   .cpu_halt_o    (cpu_halt_o),
   .blink_en_o    (blink_en_o)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
   localparam int D  = 4;
   localparam int BN = 2;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          main_pwr_ok_i = 1'b1;
   logic          disp_req_i = 1'b0, sleep_req_i = 1'b0, wake_i = 1'b0;
   logic [1:0]    boost_sel_i = 2'b00;
   logic          fast_sel_i = 1'b1;
   logic [BN-1:0] blink_sel_i = '0;
   logic [1:0]    mode_o;
   logic          core_sup_en_o, pll_en_o, pll_fast_o, cpu_halt_o;
   logic          cpu_rst_o, vol_reg_clr_o;
   logic [AW-1:0] rst_vec_o;
   logic [BN-1:0] blink_en_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pwr_mode_seq #(.DEB_LEN(D), .BLINK_N(BN), .ADDR_W(AW)) u_pwr_mode_seq (.*);

   function automatic logic [1:0] exp_next(logic [1:0] cur, bit pg, bit d, bit s, bit w);
      case (cur)
         2'd0:    return !pg ? 2'd1 : (d ? 2'd2 : 2'd0);
         2'd1:    return pg ? 2'd0 : (d ? 2'd2 : (s ? 2'd3 : 2'd1));
         default: return pg ? 2'd0 : (w ? 2'd1 : cur);
      endcase
   endfunction

   function automatic bit exp_pll(logic [1:0] m, logic [1:0] b);
      return (m <= 2'd1) ? 1'b1 : (m == 2'd2 ? (b == 2'b10) : 1'b0);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_map(logic [1:0] m, bit rst_exp);
      chk("R7 core", core_sup_en_o, (m <= 2'd1));
      chk("R7 halt", cpu_halt_o, (m >= 2'd2));
      chk("R8 pll", pll_en_o, exp_pll(m, boost_sel_i));
      chk("R8 fast", pll_fast_o, exp_pll(m, boost_sel_i) & fast_sel_i);
      chk("R9 blink", blink_en_o, (m == 2'd2) ? blink_sel_i : '0);
      chk("R10 rst", cpu_rst_o, rst_exp);
      chk("R10 clr", vol_reg_clr_o, rst_exp);
   endtask

   task automatic set_req(bit d, bit s, bit w);
      disp_req_i = d; sleep_req_i = s; wake_i = w;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [1:0] em;
      bit pg;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 mode", mode_o, 0);
      chk("R1 core", core_sup_en_o, 1);
      chk("R1 pll", pll_en_o, 1);
      chk("R1 halt", cpu_halt_o, 0);
      chk("R1 rst", cpu_rst_o, 0);
      chk("R1 clr", vol_reg_clr_o, 0);
      chk("R1 blink", blink_en_o, 0);
      tick();
      // R5: sleep request ignored in normal mode
      set_req(0, 1, 0); tick(); set_req(0, 0, 0);
      chk("R5 sleep ignored in normal", mode_o, 0);
      // R2: short glitch ignored
      main_pwr_ok_i = 1'b0;
      repeat (D - 1) tick();
      main_pwr_ok_i = 1'b1;
      repeat (D + 6) tick();
      chk("R2 glitch ignored", mode_o, 0);
      // R2/R3: exact latency of power loss
      main_pwr_ok_i = 1'b0;
      repeat (D + 2) tick();
      chk("R2 not yet", mode_o, 0);
      tick();
      chk("R3 brownout", mode_o, 1);
      chk("R3 pll kept", pll_en_o, 1);
      chk("R3 fast kept", pll_fast_o, 1);
      // R10: sleep then wake gives restart into brownout
      set_req(0, 1, 0); tick(); set_req(0, 0, 0);
      chk("R5 sleep", mode_o, 3);
      tick();
      set_req(0, 0, 1); tick(); set_req(0, 0, 0);
      chk("R10 wake mode", mode_o, 1);
      chk("R10 rst pulse", cpu_rst_o, 1);
      chk("R10 vector", rst_vec_o, 0);
      tick();
      chk("R10 pulse ends", cpu_rst_o, 0);
      // R4: power return, no restart
      main_pwr_ok_i = 1'b1;
      repeat (D + 3) tick();
      chk("R4 normal", mode_o, 0);
      chk("R4 no restart", cpu_rst_o, 0);
      // R6: display request on main power
      set_req(1, 0, 0); tick(); set_req(0, 0, 0);
      chk("R6 brief display", mode_o, 2);
      tick();
      chk("R6 back normal", mode_o, 0);
      chk("R6 restart", cpu_rst_o, 1);
      tick();

      // random phases
      em = 2'd0; pg = 1'b1;
      for (int ph = 0; ph < 8; ph++) begin
         pg = (ph % 2 == 0) ? 1'b0 : 1'b1;
         set_req(0, 0, 0);
         main_pwr_ok_i = pg;
         repeat (D + 6) tick();
         em = exp_next(em, pg, 0, 0, 0);
         chk("R3/R4 settle", mode_o, em);
         for (int i = 0; i < 80; i++) begin
            bit d, s, w;
            logic [1:0] nm;
            d = ($urandom % 6) == 0;
            s = ($urandom % 5) == 0;
            w = ($urandom % 4) == 0;
            boost_sel_i = 2'($urandom);
            fast_sel_i  = 1'($urandom);
            blink_sel_i = BN'($urandom);
            set_req(d, s, w);
            nm = exp_next(em, pg, d, s, w);
            tick();
            chk("R5/R10 mode", mode_o, nm);
            check_map(nm, (em >= 2'd2) && (nm != em));
            em = nm;
         end
      end
      set_req(0, 0, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule